// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit side of a network controller's DMA path. Software places descriptors in a ring in memory and pulses `kick_i`. The engine then walks the ring from its current index. For each descriptor it owns, it fetches one buffer fragment through a simple request/acknowledge memory port and appends that fragment to a local frame buffer. When a fragment carries the last-fragment flag, the engine streams the whole frame out as bytes. Each processed descriptor is written back with its ownership and error flags cleared. When a pass ends having sent a frame, the engine raises the transmit bit of an interrupt status register.

A frame may span several descriptors. A pass ends in one of three ways: at the first descriptor the engine does not own, after the frame with the last flag, or after `ring_size_i` descriptors have been examined. A partly gathered frame stays in the buffer until a later pass completes it. A control reset clears the transmit index, the receive index and the gathered fragment offset. A frame that would outgrow the buffer, which holds MTU plus 128 bytes, is dropped whole.

The controller has these states. `S_IDLE` waits for a kick and goes to `S_RD_PTR`, or to `S_DONE` when the ring size is zero. `S_RD_PTR` reads the buffer-address word and, on acknowledge, moves to `S_RD_CTL`. `S_RD_CTL` reads the length/flags word and, on acknowledge, moves to `S_CHECK`. `S_CHECK` goes to `S_DONE` when the descriptor is not owned, to `S_WRBACK` when the frame is being dropped or would overflow, and otherwise to `S_FETCH`. `S_FETCH` reads one byte per access; after the final byte it goes to `S_EMIT` if the descriptor has the last flag, otherwise to `S_WRBACK`. `S_EMIT` streams the frame and, after issuing the final byte, goes to `S_WRBACK`. `S_WRBACK` writes the flags back and, on acknowledge, goes to `S_DONE` for a last fragment or to `S_NEXT` otherwise. `S_NEXT` goes to `S_DONE` when the examined count has reached the ring size, and otherwise to `S_RD_PTR`. `S_DONE` posts the interrupt bit, sets idle and returns to `S_IDLE`. A control reset from any state returns the controller to `S_IDLE`.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset `idle_o` is 1, `tx_index_o`, `rx_index_o` and `irq_status_o` are 0, and `tx_valid_o` is 0.
- R2: A descriptor occupies 8 bytes at `ring_base_i + 8*index`. The word at offset 0 is the buffer address. The word at offset 4 holds the length in bits [15:0] and the flags in bits [31:16]. The engine fetches length+1 bytes from the buffer address, one byte per access, using `mem_rdata_i[7:0]`.
- R3: Fragments are appended in ring order. A frame is streamed only after a fragment with flags bit 0 (last) set has been gathered. Its bytes appear in order on `tx_data_o` with `tx_valid_o`, and `tx_last_o` is set on the final byte only.
- R4: A pass stops at the first descriptor whose flags bit 15 (owned) is clear. That descriptor is not written back and the index does not advance past it.
- R5: A pass examines at most `ring_size_i` descriptors. The index advances once for each owned descriptor and wraps to 0 when it reaches `ring_size_i`.
- R6: Each owned descriptor is written back at offset 4 with the length unchanged. Flag bits 15, 14, 6, 5, 4 and 3 and 2 are cleared and all other flag bits are kept.
- R7: If a pass sent at least one frame, bit 4 of `irq_status_o` is set and the other bits are kept; otherwise bit 4 is not set. `irq_set_i` sets bits, `irq_clr_i` clears bits, and `irq_o` is the OR of `irq_status_o & irq_mask_i`.
- R8: `idle_o` falls the cycle after an accepted kick and rises when the pass ends.
- R9: A control reset clears the transmit index, the receive index and the fragment offset, so a partly gathered frame is discarded.
- R10: A fragment that would take the gathered frame past MTU+128 bytes pulses `ovf_o`. The frame is then dropped through its last fragment and nothing is streamed. Its descriptors are still written back and the index still advances.
- R11: A partly gathered frame left when a pass stops is kept, and the next pass appends to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Start a pass (ignored while busy) |
| ctl_reset_i | input | 1 | Clear indices and fragment offset, abort pass |
| ring_base_i | input | ADDR_W | Ring base byte address |
| ring_size_i | input | IDX_W | Number of descriptors in the ring |
| mem_req_o | output | 1 | Memory access request, held until acknowledge |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of frame |
| idle_o | output | 1 | Engine is idle |
| tx_index_o | output | IDX_W | Current transmit ring index |
| rx_advance_i | input | 1 | Receive side consumed a descriptor |
| rx_index_o | output | IDX_W | Receive ring index |
| irq_set_i | input | 32 | Interrupt status bits to set |
| irq_clr_i | input | 32 | Interrupt status bits to clear |
| irq_mask_i | input | 32 | Interrupt enable mask |
| irq_status_o | output | 32 | Interrupt status register |
| irq_o | output | 1 | Interrupt request |
| ovf_o | output | 1 | One-cycle frame overflow pulse |

## Verification
`idle_o` is due low at the first falling edge after the kick, so the bench checks it there. The pass results are the final stream byte, the written-back descriptor, the index and interrupt bit 4. All of them are settled at the edge where `idle_o` rises, because bit 4 and idle are registered on the same edge as the controller leaves `S_DONE`. The bench therefore waits for `idle_o` and samples everything at that falling edge. Each memory access takes two cycles with the bench memory, and stream bytes are collected at every falling edge while `tx_valid_o` is high. Interrupt status and the receive index respond one cycle after their inputs and are sampled at the next falling edge.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_PTR,
        S_RD_CTL,
        S_CHECK,
        S_FETCH,
        S_EMIT,
        S_WRBACK,
        S_NEXT,
        S_DONE
    } tx_state_e;

    localparam int          FLG_OWN      = 15;
    localparam int          FLG_LAST     = 0;
    // owned, error, underflow, late collision, carrier lost, deferred, retry
    localparam logic [15:0] FLG_CLR_MASK = 16'hC07C;
    localparam int          IRQ_TX_BIT   = 4;

endpackage

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
    parameter int DEPTH = 1628,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            store[waddr_i] <= wdata_i;
        end
        rdata_o <= store[raddr_i];
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(waddr_i) < DEPTH));

endmodule

// File: rtl/tx_ring_status.sv
module tx_ring_status
    import tx_ring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_reset_i,
    input  logic             rx_advance_i,
    input  logic             tx_done_i,
    input  logic [31:0]      irq_set_i,
    input  logic [31:0]      irq_clr_i,
    input  logic [31:0]      irq_mask_i,
    output logic [31:0]      irq_status_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] rx_index_o
);

    logic [31:0] status_d;

    always_comb begin
        status_d = (irq_status_o & ~irq_clr_i) | irq_set_i;
        if (tx_done_i) begin
            status_d[IRQ_TX_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_status_o <= '0;
            rx_index_o   <= '0;
        end else begin
            irq_status_o <= status_d;
            if (ctl_reset_i) begin
                rx_index_o <= '0;
            end else if (rx_advance_i) begin
                rx_index_o <= rx_index_o + 1'b1;
            end
        end
    end

    assign irq_o = |(irq_status_o & irq_mask_i);

    assert_irq_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i == '0) |=> ((irq_status_o & $past(irq_status_o)) == $past(irq_status_o)));

    assert_tx_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> irq_status_o[IRQ_TX_BIT]);

    assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset_i |=> (rx_index_o == '0));

endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 8,
    parameter int FRAME_BYTES = 1628,
    parameter int OFF_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_i,
    input  logic              ctl_reset_i,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic [IDX_W-1:0]  ring_size_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              fb_we_o,
    output logic [OFF_W-1:0]  fb_waddr_o,
    output logic [7:0]        fb_wdata_o,
    output logic [OFF_W-1:0]  fb_raddr_o,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    output logic              idle_o,
    output logic [IDX_W-1:0]  tx_index_o,
    output logic              ovf_o,
    output logic              tx_done_o
);

    localparam int CNT_W = IDX_W + 1;

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] desc_addr_q;
    logic [ADDR_W-1:0] bufp_q;
    logic [15:0]       len_q;
    logic [15:0]       flags_q;
    logic [16:0]       remain_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  rdp_q;
    logic              drop_q;
    logic              sent_q;
    logic              idle_q;
    logic              emit_v_q;
    logic              emit_last_q;
    logic              ovf_q;

    logic [17:0]       need_w;
    logic              ovf_now;
    logic              owned;
    logic              last_frag;
    logic              emit_end;
    logic [ADDR_W-1:0] next_desc_addr;
    logic [IDX_W-1:0]  idx_next;

    assign need_w         = 18'(off_q) + 18'(len_q) + 18'd1;
    assign ovf_now        = need_w > 18'(FRAME_BYTES);
    assign owned          = flags_q[FLG_OWN];
    assign last_frag      = flags_q[FLG_LAST];
    assign emit_end       = (rdp_q == OFF_W'(off_q - 1'b1));
    assign next_desc_addr = ring_base_i + (ADDR_W'(idx_q) << 3);
    assign idx_next       = ((CNT_W'(idx_q) + 1'b1) == CNT_W'(ring_size_i)) ? '0 : idx_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (kick_i) state_d = (ring_size_i == '0) ? S_DONE : S_RD_PTR;
            S_RD_PTR: if (mem_ack_i) state_d = S_RD_CTL;
            S_RD_CTL: if (mem_ack_i) state_d = S_CHECK;
            S_CHECK: begin
                if (!owned)                 state_d = S_DONE;
                else if (drop_q || ovf_now) state_d = S_WRBACK;
                else                        state_d = S_FETCH;
            end
            S_FETCH:  if (mem_ack_i && remain_q == 17'd1) state_d = last_frag ? S_EMIT : S_WRBACK;
            S_EMIT:   if (emit_end) state_d = S_WRBACK;
            S_WRBACK: if (mem_ack_i) state_d = last_frag ? S_DONE : S_NEXT;
            S_NEXT:   state_d = (count_q == CNT_W'(ring_size_i)) ? S_DONE : S_RD_PTR;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (ctl_reset_i) begin
            state_d = S_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            count_q     <= '0;
            desc_addr_q <= '0;
            bufp_q      <= '0;
            len_q       <= '0;
            flags_q     <= '0;
            remain_q    <= '0;
            off_q       <= '0;
            rdp_q       <= '0;
            drop_q      <= 1'b0;
            sent_q      <= 1'b0;
            idle_q      <= 1'b1;
            emit_v_q    <= 1'b0;
            emit_last_q <= 1'b0;
            ovf_q       <= 1'b0;
        end else if (ctl_reset_i) begin
            idx_q       <= '0;
            off_q       <= '0;
            drop_q      <= 1'b0;
            sent_q      <= 1'b0;
            idle_q      <= 1'b1;
            emit_v_q    <= 1'b0;
            emit_last_q <= 1'b0;
            ovf_q       <= 1'b0;
        end else begin
            emit_v_q    <= 1'b0;
            emit_last_q <= 1'b0;
            ovf_q       <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (kick_i) begin
                        desc_addr_q <= next_desc_addr;
                        count_q     <= '0;
                        sent_q      <= 1'b0;
                        idle_q      <= 1'b0;
                    end
                end
                S_RD_PTR: begin
                    if (mem_ack_i) bufp_q <= mem_rdata_i[ADDR_W-1:0];
                end
                S_RD_CTL: begin
                    if (mem_ack_i) begin
                        len_q   <= mem_rdata_i[15:0];
                        flags_q <= mem_rdata_i[31:16];
                    end
                end
                S_CHECK: begin
                    if (owned) begin
                        idx_q   <= idx_next;
                        count_q <= count_q + 1'b1;
                        rdp_q   <= '0;
                        if (!drop_q) begin
                            if (ovf_now) begin
                                drop_q <= 1'b1;
                                off_q  <= '0;
                                ovf_q  <= 1'b1;
                            end else begin
                                remain_q <= 17'(len_q) + 17'd1;
                            end
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_ack_i) begin
                        off_q    <= off_q + 1'b1;
                        bufp_q   <= bufp_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                S_EMIT: begin
                    rdp_q       <= rdp_q + 1'b1;
                    emit_v_q    <= 1'b1;
                    emit_last_q <= emit_end;
                    if (emit_end) begin
                        off_q  <= '0;
                        sent_q <= 1'b1;
                    end
                end
                S_WRBACK: begin
                    if (mem_ack_i && last_frag) drop_q <= 1'b0;
                end
                S_NEXT: begin
                    desc_addr_q <= next_desc_addr;
                end
                S_DONE: begin
                    idle_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = desc_addr_q;
        mem_wdata_o = {flags_q & ~FLG_CLR_MASK, len_q};
        fb_we_o     = 1'b0;
        unique case (state_q)
            S_RD_PTR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr_q;
            end
            S_RD_CTL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr_q + ADDR_W'(4);
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = bufp_q;
                fb_we_o    = mem_ack_i;
            end
            S_WRBACK: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = desc_addr_q + ADDR_W'(4);
            end
            default: ;
        endcase
    end

    assign fb_waddr_o = off_q;
    assign fb_wdata_o = mem_rdata_i[7:0];
    assign fb_raddr_o = rdp_q;
    assign tx_valid_o = emit_v_q;
    assign tx_last_o  = emit_last_q;
    assign idle_o     = idle_q;
    assign tx_index_o = idx_q;
    assign ovf_o      = ovf_q;
    assign tx_done_o  = (state_q == S_DONE) && sent_q;

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !ctl_reset_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    assert_idx_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_index_o) |-> ($past(ctl_reset_i) || $past(state_q == S_CHECK && owned)));

    assert_kick_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && kick_i && !ctl_reset_i) |=> !idle_o);

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int MTU    = 1500,
    parameter int SLACK  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_i,
    input  logic              ctl_reset_i,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic [IDX_W-1:0]  ring_size_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    output logic              idle_o,
    output logic [IDX_W-1:0]  tx_index_o,
    input  logic              rx_advance_i,
    output logic [IDX_W-1:0]  rx_index_o,
    input  logic [31:0]       irq_set_i,
    input  logic [31:0]       irq_clr_i,
    input  logic [31:0]       irq_mask_i,
    output logic [31:0]       irq_status_o,
    output logic              irq_o,
    output logic              ovf_o
);

    localparam int FRAME_BYTES = MTU + SLACK;
    localparam int OFF_W       = $clog2(FRAME_BYTES + 1);

    logic             fb_we;
    logic [OFF_W-1:0] fb_waddr;
    logic [7:0]       fb_wdata;
    logic [OFF_W-1:0] fb_raddr;
    logic             tx_done;

    tx_ring_ctrl #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .FRAME_BYTES (FRAME_BYTES),
        .OFF_W       (OFF_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_i      (kick_i),
        .ctl_reset_i (ctl_reset_i),
        .ring_base_i (ring_base_i),
        .ring_size_i (ring_size_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .fb_we_o     (fb_we),
        .fb_waddr_o  (fb_waddr),
        .fb_wdata_o  (fb_wdata),
        .fb_raddr_o  (fb_raddr),
        .tx_valid_o  (tx_valid_o),
        .tx_last_o   (tx_last_o),
        .idle_o      (idle_o),
        .tx_index_o  (tx_index_o),
        .ovf_o       (ovf_o),
        .tx_done_o   (tx_done)
    );

    tx_frame_buf #(
        .DEPTH (FRAME_BYTES),
        .AW    (OFF_W)
    ) fbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (fb_we),
        .waddr_i (fb_waddr),
        .wdata_i (fb_wdata),
        .raddr_i (fb_raddr),
        .rdata_o (tx_data_o)
    );

    tx_ring_status #(
        .IDX_W (IDX_W)
    ) stat_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_reset_i  (ctl_reset_i),
        .rx_advance_i (rx_advance_i),
        .tx_done_i    (tx_done),
        .irq_set_i    (irq_set_i),
        .irq_clr_i    (irq_clr_i),
        .irq_mask_i   (irq_mask_i),
        .irq_status_o (irq_status_o),
        .irq_o        (irq_o),
        .rx_index_o   (rx_index_o)
    );

endmodule

// File: tb/tx_ring_engine_tb.sv
module tx_ring_engine_tb_top;

    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kick = 1'b0;
    logic        creset = 1'b0;
    logic [31:0] ring_base = BASE;
    logic [7:0]  ring_size = 8'd4;
    logic        mem_req, mem_we, mack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mrd = '0;
    logic        tx_valid, tx_last, idle, irq, ovf;
    logic [7:0]  tx_data, tx_index, rx_index;
    logic        rx_adv = 1'b0;
    logic [31:0] irq_set = '0, irq_clr = '0, irq_mask = '0, irq_status;

    always #4 clk = ~clk;

    tx_ring_engine #(.MTU(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .ctl_reset_i(creset),
        .ring_base_i(ring_base), .ring_size_i(ring_size),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mrd), .mem_ack_i(mack),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
        .idle_o(idle), .tx_index_o(tx_index), .rx_advance_i(rx_adv),
        .rx_index_o(rx_index), .irq_set_i(irq_set), .irq_clr_i(irq_clr),
        .irq_mask_i(irq_mask), .irq_status_o(irq_status), .irq_o(irq), .ovf_o(ovf)
    );

    // byte-addressed little-endian memory, two cycles per access
    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        logic [11:0] a;
        a = mem_addr[11:0];
        if (mem_req && !mack) begin
            mack <= 1'b1;
            mrd  <= {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
            if (mem_we) begin
                mem[a]       <= mem_wdata[7:0];
                mem[a+12'd1] <= mem_wdata[15:8];
                mem[a+12'd2] <= mem_wdata[23:16];
                mem[a+12'd3] <= mem_wdata[31:24];
            end
        end else begin
            mack <= 1'b0;
        end
    end

    // output capture
    logic [7:0]  cap [0:511];
    int          cap_n = 0, last_n = 0, ovf_n = 0;
    logic [31:0] first_addr = '0;
    bit          seen = 1'b0;
    always @(negedge clk) begin
        if (tx_valid) begin
            cap[cap_n] = tx_data;
            cap_n++;
            if (tx_last) last_n++;
        end
        if (ovf) ovf_n++;
        if (mem_req && !seen) begin
            first_addr = mem_addr;
            seen = 1'b1;
        end
    end

    int   checks = 0, failures = 0;
    bit   done = 1'b0;
    logic [7:0] exp_b [0:511];
    int   exp_n = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rd32(input logic [31:0] ad);
        logic [11:0] a = ad[11:0];
        return {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
    endfunction

    task automatic wr32(input logic [31:0] ad, input logic [31:0] d);
        logic [11:0] a = ad[11:0];
        mem[a] = d[7:0]; mem[a+12'd1] = d[15:8]; mem[a+12'd2] = d[23:16]; mem[a+12'd3] = d[31:24];
    endtask

    task automatic set_desc(input int idx, input logic [31:0] bp, input logic [15:0] len, input logic [15:0] fl);
        wr32(BASE + 32'(idx * 8), bp);
        wr32(BASE + 32'(idx * 8) + 32'd4, {fl, len});
    endtask

    task automatic fill(input logic [31:0] bp, input int n, input logic [7:0] seed);
        for (int k = 0; k < n; k++) mem[bp[11:0] + 12'(k)] = seed + 8'(k);
    endtask

    task automatic exp_add(input logic [31:0] bp, input int n);
        for (int k = 0; k < n; k++) begin
            exp_b[exp_n] = mem[bp[11:0] + 12'(k)];
            exp_n++;
        end
    endtask

    task automatic run_pass();
        int t;
        cap_n = 0; last_n = 0; seen = 1'b0;
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        chk(idle == 1'b0, "R8 idle low after kick", idle, 0);
        t = 0;
        while (!idle && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(idle == 1'b1, "R8 idle high at pass end", idle, 1);
    endtask

    task automatic check_frame(input string req);
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++)
            if (cap[k] !== exp_b[k]) chk(1'b0, req, cap[k], exp_b[k]);
        chk(last_n == ((exp_n > 0) ? 1 : 0), req, last_n, (exp_n > 0) ? 1 : 0);
    endtask

    task automatic pulse_creset();
        @(negedge clk) creset = 1'b1;
        @(negedge clk) creset = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = '1;
        @(negedge clk) irq_clr = '0;
    endtask

    // {length, seed}
    localparam logic [23:0] VEC [4] = '{
        {16'd0,  8'h10},
        {16'd3,  8'h20},
        {16'd7,  8'h40},
        {16'd63, 8'h80}
    };

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(tx_index == 0 && rx_index == 0, "R1 indices", {tx_index, rx_index}, 0);
        chk(irq_status == 0, "R1 irq status", irq_status, 0);
        chk(tx_valid == 0, "R1 stream", tx_valid, 0);

        // table of single-fragment frames walking a 4-entry ring
        pulse_creset();
        for (int i = 0; i < 4; i++) begin
            logic [15:0] ln = VEC[i][23:8];
            logic [31:0] bp = 32'h400 + 32'(i * 128);
            set_desc(i, bp, ln, 16'h8121);
            set_desc((i + 1) % 4, 32'h0, 16'h0, 16'h0);
            fill(bp, int'(ln) + 1, VEC[i][7:0]);
            exp_n = 0;
            exp_add(bp, int'(ln) + 1);
            run_pass();
            check_frame("R3 R2 single fragment frame");
            chk(tx_index == 8'((i + 1) % 4), "R5 index advance and wrap", tx_index, (i + 1) % 4);
            chk(rd32(BASE + 32'(i * 8) + 32'd4) == {16'h0101, ln}, "R6 writeback",
                rd32(BASE + 32'(i * 8) + 32'd4), {16'h0101, ln});
            chk(irq_status[4] == 1'b1, "R7 tx bit set", irq_status, 32'h10);
            clear_irq();
        end

        // R3 frame across two descriptors
        pulse_creset();
        ring_size = 8'd8;
        set_desc(0, 32'h600, 16'd4, 16'h8000);
        set_desc(1, 32'h680, 16'd2, 16'h8001);
        set_desc(2, 32'h0, 16'd0, 16'h0);
        fill(32'h600, 5, 8'hA0);
        fill(32'h680, 3, 8'hB0);
        exp_n = 0;
        exp_add(32'h600, 5);
        exp_add(32'h680, 3);
        run_pass();
        check_frame("R3 multi fragment");
        chk(tx_index == 8'd2, "R3 index after two fragments", tx_index, 2);
        chk(rd32(BASE + 32'd4) == 32'h0000_0004, "R6 middle fragment writeback", rd32(BASE + 32'd4), 32'h4);
        clear_irq();

        // R5 ring size limit, then R11 carry-over of partial frame
        pulse_creset();
        ring_size = 8'd2;
        set_desc(0, 32'h600, 16'd2, 16'h8000);
        set_desc(1, 32'h680, 16'd1, 16'h8000);
        set_desc(2, 32'h700, 16'd0, 16'h8001);
        fill(32'h600, 3, 8'hC0);
        fill(32'h680, 2, 8'hD0);
        run_pass();
        chk(cap_n == 0, "R5 no frame within ring limit", cap_n, 0);
        chk(tx_index == 8'd0, "R5 wrap at ring size", tx_index, 0);
        chk(irq_status[4] == 1'b0, "R7 no tx bit without frame", irq_status, 0);
        chk(rd32(BASE + 32'd20) == 32'h8001_0000, "R5 descriptor past limit untouched",
            rd32(BASE + 32'd20), 32'h8001_0000);
        ring_size = 8'd8;
        set_desc(0, 32'h780, 16'd1, 16'h8001);
        fill(32'h780, 2, 8'hE0);
        exp_n = 0;
        exp_add(32'h600, 3);
        exp_add(32'h680, 2);
        exp_add(32'h780, 2);
        run_pass();
        check_frame("R11 carried partial frame");
        chk(tx_index == 8'd1, "R11 index", tx_index, 1);
        clear_irq();

        // R4 stop at unowned descriptor
        set_desc(1, 32'h700, 16'd5, 16'h0120);
        run_pass();
        chk(cap_n == 0, "R4 no frame", cap_n, 0);
        chk(tx_index == 8'd1, "R4 index held", tx_index, 1);
        chk(rd32(BASE + 32'd12) == 32'h0120_0005, "R4 no writeback", rd32(BASE + 32'd12), 32'h0120_0005);
        chk(first_addr == BASE + 32'd8, "R2 descriptor address", first_addr, BASE + 32'd8);

        // R7 other interrupt bits kept, mask
        @(negedge clk) irq_set = 32'h2;
        @(negedge clk) irq_set = '0;
        set_desc(1, 32'h700, 16'd0, 16'h8001);
        set_desc(2, 32'h0, 16'd0, 16'h0);
        run_pass();
        chk(irq_status == 32'h12, "R7 bits kept", irq_status, 32'h12);
        @(negedge clk) irq_mask = 32'h10;
        @(negedge clk) chk(irq == 1'b1, "R7 masked irq on", irq, 1);
        irq_mask = 32'h1;
        @(negedge clk) chk(irq == 1'b0, "R7 masked irq off", irq, 0);
        irq_mask = '0;
        clear_irq();

        // R10 overflow drops frame
        pulse_creset();
        ovf_n = 0;
        set_desc(0, 32'h400, 16'd99, 16'h8000);
        set_desc(1, 32'h500, 16'd59, 16'h8001);
        set_desc(2, 32'h600, 16'd2, 16'h8001);
        set_desc(3, 32'h0, 16'd0, 16'h0);
        fill(32'h600, 3, 8'hF0);
        run_pass();
        chk(cap_n == 0, "R10 dropped frame", cap_n, 0);
        chk(ovf_n == 1, "R10 overflow pulse", ovf_n, 1);
        chk(tx_index == 8'd2, "R10 index advances", tx_index, 2);
        chk(rd32(BASE + 32'd12) == {16'h0001, 16'd59}, "R10 writeback", rd32(BASE + 32'd12), {16'h0001, 16'd59});
        chk(irq_status[4] == 1'b0, "R10 no tx bit", irq_status, 0);
        exp_n = 0;
        exp_add(32'h600, 3);
        run_pass();
        check_frame("R10 next frame intact");

        // R9 control reset
        @(negedge clk) rx_adv = 1'b1;
        @(negedge clk);
        @(negedge clk) rx_adv = 1'b0;
        chk(rx_index == 8'd2, "R9 rx index counted", rx_index, 2);
        set_desc(3, 32'h780, 16'd2, 16'h8000);
        set_desc(4, 32'h0, 16'd0, 16'h0);
        run_pass();
        pulse_creset();
        @(negedge clk);
        chk(tx_index == 8'd0 && rx_index == 8'd0, "R9 indices cleared", {tx_index, rx_index}, 0);
        set_desc(0, 32'h700, 16'd1, 16'h8001);
        set_desc(1, 32'h0, 16'd0, 16'h0);
        fill(32'h700, 2, 8'h55);
        exp_n = 0;
        exp_add(32'h700, 2);
        run_pass();
        check_frame("R9 offset cleared");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule